// File: doc/BRIEF.md
# Bitfield Execution Unit

This unit carries out four 32-bit bitfield operations for an integer pipeline: zeroing a contiguous field of a destination value, merging the low bits of a source value into a field of a destination value, and pulling a field out of a source value either zero-extended or sign-extended. The issue stage supplies the operand values already read from the register file. It also supplies the two 5-bit immediates, a flag for each of the destination and source register numbers that says whether that register is the program counter, and the outcome of the condition check.

The field forms differ by operation. Clear and insert describe the field by its lowest and highest bit positions. The two extracts describe it by its lowest bit position and its width minus one. Each operation screens its own operands for combinations whose outcome is architecturally undefined. Such an operation raises an unpredictable flag instead of writing. If the operands are legal and the condition fails, the operation retires without a write.

The result and its flags are registered. They appear one clock after the issue strobe, qualified by a single-cycle valid pulse.

Top module: `bitfield_unit`

## Requirements
- R1: Opcode 0 (clear) returns the destination value with bits lsb through msb (inclusive) forced to zero and all other bits unchanged.
- R2: Opcode 1 (insert) returns the destination value with bits lsb through msb replaced by the low (msb-lsb+1) bits of the source value; bits outside the field come from the destination.
- R3: Opcode 2 (unsigned extract) returns source bits lsb through lsb+hi in the low bits of the result, where hi is width minus one; all higher result bits are zero.
- R4: Opcode 3 (signed extract) returns the same field as R3, but every result bit above the field is a copy of the field's top bit.
- R5: A field that spans all 32 bits (lsb 0 with msb 31, or lsb 0 with width-minus-one 31) works for every opcode: clear gives zero, and insert and both extracts give the source value.
- R6: For clear and insert, an msb below lsb raises unpred_o and keeps wr_en_o low.
- R7: For both extracts, lsb plus width-minus-one of 32 or more raises unpred_o and keeps wr_en_o low; a sum of exactly 31 is legal.
- R8: rd_is_pc_i raises unpred_o for every opcode. rn_is_pc_i raises unpred_o for the two extracts only and has no effect on clear or insert.
- R9: With legal operands and cond_ok_i low, valid_o pulses with wr_en_o low, unpred_o low and result_o zero.
- R10: The unpredictable checks take priority over the condition: an unpredictable operation reports unpred_o high whatever cond_ok_i is, and wr_en_o stays low.
- R11: valid_o is high exactly in the cycle after each cycle with issue_i high, so back-to-back issues give back-to-back pulses; wr_en_o and unpred_o are never high without valid_o, and result_o is zero whenever valid_o is high with wr_en_o low.
- R12: After reset, valid_o, wr_en_o and unpred_o are low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | One operation is presented this cycle |
| op_i | input | 2 | 0 clear, 1 insert, 2 unsigned extract, 3 signed extract |
| cond_ok_i | input | 1 | Condition passed for this operation |
| rd_is_pc_i | input | 1 | Destination register number names the program counter |
| rn_is_pc_i | input | 1 | Source register number names the program counter |
| dst_val_i | input | 32 | Current destination register value |
| src_val_i | input | 32 | Source register value |
| lsb_i | input | 5 | Lowest bit of the field |
| hi_i | input | 5 | msb for clear/insert, width minus one for extracts |
| valid_o | output | 1 | Result and flags are meaningful this cycle |
| wr_en_o | output | 1 | Destination register is written with result_o |
| unpred_o | output | 1 | Operand combination is unpredictable |
| result_o | output | 32 | Value to write |

## Verification
The assertions assume that the operand fields are stable while issue_i is high and that reset is applied before the first issue. They also assume that op_i carries one of the four defined codes. The stimulus drives every input at the falling edge, holds it through the following rising edge, and uses only the four opcodes. The illegal cases come from deliberate immediates, one on each side of every boundary, and not from undriven or unknown bits.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic [1:0] {
        BF_CLEAR  = 2'd0,
        BF_INSERT = 2'd1,
        BF_UEXT   = 2'd2,
        BF_SEXT   = 2'd3
    } bf_op_e;

endpackage

// File: rtl/bfu_mask_gen.sv
// Builds a run of 'count' ones (1..XLEN) and the same run moved up by 'shift'.
module bfu_mask_gen #(
    parameter int XLEN = 32,
    parameter int IDXW = $clog2(XLEN)
) (
    input  logic [IDXW:0]   count,
    input  logic [IDXW-1:0] shift,
    output logic [XLEN-1:0] low_mask,
    output logic [XLEN-1:0] placed_mask
);
    localparam logic [XLEN:0] ONE_W = {{XLEN{1'b0}}, 1'b1};

    logic [XLEN:0] wide_d;

    always_comb begin
        // one spare bit so that count == XLEN yields all ones without overflow
        wide_d      = (ONE_W << count) - ONE_W;
        low_mask    = wide_d[XLEN-1:0];
        placed_mask = low_mask << shift;
    end
endmodule

// File: rtl/bfu_check.sv
// Per-operation screening for unpredictable operand combinations.
module bfu_check
    import bfu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDXW = $clog2(XLEN)
) (
    input  bf_op_e          op,
    input  logic            rd_is_pc,
    input  logic            rn_is_pc,
    input  logic [IDXW-1:0] lsb,
    input  logic [IDXW-1:0] hi,
    output logic            unpred
);
    localparam logic [IDXW:0] XLEN_W = (IDXW+1)'(XLEN);

    logic [IDXW:0] top_d;
    logic          order_bad_d;
    logic          span_bad_d;

    always_comb begin
        top_d       = {1'b0, lsb} + {1'b0, hi};
        order_bad_d = (hi < lsb);
        span_bad_d  = (top_d >= XLEN_W);
        unpred      = rd_is_pc;
        unique case (op)
            BF_CLEAR, BF_INSERT: unpred = unpred | order_bad_d;
            default:             unpred = unpred | rn_is_pc | span_bad_d;
        endcase
    end
endmodule

// File: rtl/bfu_datapath.sv
// Combinational result for all four field operations.
module bfu_datapath
    import bfu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDXW = $clog2(XLEN)
) (
    input  bf_op_e          op,
    input  logic [XLEN-1:0] dst,
    input  logic [XLEN-1:0] src,
    input  logic [IDXW-1:0] lsb,
    input  logic [IDXW-1:0] hi,
    output logic [XLEN-1:0] result
);
    localparam logic [IDXW:0] XLEN_W = (IDXW+1)'(XLEN);
    localparam logic [IDXW:0] ONE_C  = {{IDXW{1'b0}}, 1'b1};

    logic [IDXW:0]   cnt_d;
    logic [IDXW:0]   up_d;
    logic [IDXW:0]   down_d;
    logic [XLEN-1:0] low_w;
    logic [XLEN-1:0] placed_w;
    logic [XLEN-1:0] lifted_d;

    always_comb begin
        if (op == BF_CLEAR || op == BF_INSERT) begin
            cnt_d = {1'b0, hi} - {1'b0, lsb} + ONE_C;
        end else begin
            cnt_d = {1'b0, hi} + ONE_C;
        end
    end

    bfu_mask_gen #(.XLEN(XLEN), .IDXW(IDXW)) u_mask (
        .count       (cnt_d),
        .shift       (lsb),
        .low_mask    (low_w),
        .placed_mask (placed_w)
    );

    always_comb begin
        up_d     = XLEN_W - cnt_d - {1'b0, lsb};
        down_d   = XLEN_W - cnt_d;
        lifted_d = src << up_d;
        unique case (op)
            BF_CLEAR:  result = dst & ~placed_w;
            BF_INSERT: result = (dst & ~placed_w) | ((src << lsb) & placed_w);
            BF_UEXT:   result = (src >> lsb) & low_w;
            default:   result = XLEN'($signed(lifted_d) >>> down_d);
        endcase
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int IDXW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [1:0]      op_i,
    input  logic            cond_ok_i,
    input  logic            rd_is_pc_i,
    input  logic            rn_is_pc_i,
    input  logic [XLEN-1:0] dst_val_i,
    input  logic [XLEN-1:0] src_val_i,
    input  logic [IDXW-1:0] lsb_i,
    input  logic [IDXW-1:0] hi_i,
    output logic            valid_o,
    output logic            wr_en_o,
    output logic            unpred_o,
    output logic [XLEN-1:0] result_o
);
    typedef struct packed {
        logic            vld;
        logic            wr;
        logic            unp;
        logic [XLEN-1:0] res;
    } bfu_state_t;

    bfu_state_t state_d, state_q;
    bf_op_e     op_w;
    logic       unpred_w;
    logic [XLEN-1:0] dp_res_w;

    assign op_w = bf_op_e'(op_i);

    bfu_check #(.XLEN(XLEN), .IDXW(IDXW)) u_check (
        .op       (op_w),
        .rd_is_pc (rd_is_pc_i),
        .rn_is_pc (rn_is_pc_i),
        .lsb      (lsb_i),
        .hi       (hi_i),
        .unpred   (unpred_w)
    );

    bfu_datapath #(.XLEN(XLEN), .IDXW(IDXW)) u_dp (
        .op     (op_w),
        .dst    (dst_val_i),
        .src    (src_val_i),
        .lsb    (lsb_i),
        .hi     (hi_i),
        .result (dp_res_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = issue_i;
        state_d.wr  = 1'b0;
        state_d.unp = 1'b0;
        if (issue_i) begin
            state_d.unp = unpred_w;
            state_d.wr  = !unpred_w && cond_ok_i;
            state_d.res = state_d.wr ? dp_res_w : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_o  = state_q.vld;
    assign wr_en_o  = state_q.wr;
    assign unpred_o = state_q.unp;
    assign result_o = state_q.res;
endmodule

module bfu_checker #(
    parameter int XLEN = 32,
    parameter int IDXW = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_i,
    input logic [1:0]      op_i,
    input logic            cond_ok_i,
    input logic            rd_is_pc_i,
    input logic            rn_is_pc_i,
    input logic [IDXW-1:0] lsb_i,
    input logic [IDXW-1:0] hi_i,
    input logic            valid_o,
    input logic            wr_en_o,
    input logic            unpred_o,
    input logic [XLEN-1:0] result_o
);
    // R11
    valid_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> valid_o);

    // R11
    idle_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !valid_o);

    // R11
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o || unpred_o) |-> valid_o);

    // R10
    no_write_when_unpred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unpred_o |-> !wr_en_o);

    // R8
    dest_pc_unpred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && rd_is_pc_i) |=> unpred_o);

    // R6
    order_unpred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !op_i[1] && (hi_i < lsb_i)) |=> (unpred_o && !wr_en_o));

    // R7
    span_unpred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i[1] && (({1'b0, lsb_i} + {1'b0, hi_i}) >= (IDXW+1)'(XLEN)))
        |=> unpred_o);

    // R9
    cond_fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !cond_ok_i) |=> !wr_en_o);

    // R9
    silent_result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !wr_en_o) |-> (result_o == '0));
endmodule

bind bitfield_unit bfu_checker #(.XLEN(XLEN), .IDXW(IDXW)) u_bfu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .op_i       (op_i),
    .cond_ok_i  (cond_ok_i),
    .rd_is_pc_i (rd_is_pc_i),
    .rn_is_pc_i (rn_is_pc_i),
    .lsb_i      (lsb_i),
    .hi_i       (hi_i),
    .valid_o    (valid_o),
    .wr_en_o    (wr_en_o),
    .unpred_o   (unpred_o),
    .result_o   (result_o)
);

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;

    typedef struct {
        logic        wr;
        logic        unp;
        logic [31:0] res;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic        cond_ok_i = 1'b0;
    logic        rd_is_pc_i = 1'b0;
    logic        rn_is_pc_i = 1'b0;
    logic [31:0] dst_val_i = '0;
    logic [31:0] src_val_i = '0;
    logic [4:0]  lsb_i = '0;
    logic [4:0]  hi_i = '0;
    logic        valid_o;
    logic        wr_en_o;
    logic        unpred_o;
    logic [31:0] result_o;

    int   checks = 0;
    int   errors = 0;
    int   issued = 0;
    int   pulses = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    bitfield_unit u_bitfield_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue_i),
        .op_i       (op_i),
        .cond_ok_i  (cond_ok_i),
        .rd_is_pc_i (rd_is_pc_i),
        .rn_is_pc_i (rn_is_pc_i),
        .dst_val_i  (dst_val_i),
        .src_val_i  (src_val_i),
        .lsb_i      (lsb_i),
        .hi_i       (hi_i),
        .valid_o    (valid_o),
        .wr_en_o    (wr_en_o),
        .unpred_o   (unpred_o),
        .result_o   (result_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-by-bit reference model written from the requirements.
    function automatic exp_t model(input int op, input logic [31:0] d, input logic [31:0] s,
                                   input int lo, input int hv, input logic cond,
                                   input logic rdpc, input logic rnpc, input string tag);
        exp_t e;
        int   w;
        e.tag = tag;
        e.res = '0;
        if (op < 2) e.unp = rdpc || (hv < lo);
        else        e.unp = rdpc || rnpc || (lo + hv >= 32);
        e.wr = !e.unp && cond;
        if (e.wr) begin
            for (int i = 0; i < 32; i++) begin
                case (op)
                    0: e.res[i] = (i >= lo && i <= hv) ? 1'b0 : d[i];
                    1: e.res[i] = (i >= lo && i <= hv) ? s[i - lo] : d[i];
                    2: begin
                        w = hv + 1;
                        e.res[i] = (i < w) ? s[lo + i] : 1'b0;
                    end
                    default: begin
                        w = hv + 1;
                        e.res[i] = (i < w) ? s[lo + i] : s[lo + w - 1];
                    end
                endcase
            end
        end
        return e;
    endfunction

    // Driver: presents one operation for one cycle and records its expectation.
    task automatic drive(input int op, input logic [31:0] d, input logic [31:0] s,
                         input int lo, input int hv, input logic cond,
                         input logic rdpc, input logic rnpc, input string tag);
        issue_i    = 1'b1;
        op_i       = 2'(op);
        dst_val_i  = d;
        src_val_i  = s;
        lsb_i      = 5'(lo);
        hi_i       = 5'(hv);
        cond_ok_i  = cond;
        rd_is_pc_i = rdpc;
        rn_is_pc_i = rnpc;
        sb_q.push_back(model(op, d, s, lo, hv, cond, rdpc, rnpc, tag));
        issued++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        issue_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares each valid result with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!valid_o && (wr_en_o || unpred_o)) begin
                check("R11 flag without valid", {30'd0, wr_en_o, unpred_o}, 32'd0);
            end
            if (valid_o) begin
                pulses++;
                if (sb_q.size() == 0) begin
                    check("R11 unexpected valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " unpred"}, {31'd0, unpred_o}, {31'd0, e.unp});
                    check({e.tag, " wr_en"},  {31'd0, wr_en_o},  {31'd0, e.wr});
                    check({e.tag, " result"}, result_o, e.res);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 valid", {31'd0, valid_o}, 32'd0);
        check("R12 wr_en", {31'd0, wr_en_o}, 32'd0);
        check("R12 unpred", {31'd0, unpred_o}, 32'd0);
        check("R12 result", result_o, 32'd0);
        rst_n = 1'b1;
        idle(2);
        check("R11 idle valid", {31'd0, valid_o}, 32'd0);

        // R1 clear
        drive(0, 32'hFFFF_FFFF, 32'h0, 4, 11, 1, 0, 0, "R1");
        drive(0, 32'h1234_5678, 32'h0, 31, 31, 1, 0, 0, "R1");
        // R2 insert
        drive(1, 32'h0, 32'h0000_ABCD, 8, 15, 1, 0, 0, "R2");
        drive(1, 32'h1234_5678, 32'hFFFF_FFFF, 0, 3, 1, 0, 0, "R2");
        drive(1, 32'hAAAA_AAAA, 32'h0000_0005, 29, 31, 1, 0, 0, "R2");
        // R3 unsigned extract
        drive(2, 32'h0, 32'hDEAD_BEEF, 8, 7, 1, 0, 0, "R3");
        drive(2, 32'h0, 32'hDEAD_BEEF, 28, 3, 1, 0, 0, "R3");
        // R4 signed extract
        drive(3, 32'h0, 32'h0000_0F00, 8, 3, 1, 0, 0, "R4");
        drive(3, 32'h0, 32'h0000_0700, 8, 3, 1, 0, 0, "R4");
        drive(3, 32'h0, 32'h8000_0000, 31, 0, 1, 0, 0, "R4");
        idle(1);
        check("R11 gap valid", {31'd0, valid_o}, 32'd0);

        // R5 full-width fields
        drive(0, 32'hCAFE_F00D, 32'h0, 0, 31, 1, 0, 0, "R5");
        drive(1, 32'hCAFE_F00D, 32'h8765_4321, 0, 31, 1, 0, 0, "R5");
        drive(2, 32'h0, 32'h8765_4321, 0, 31, 1, 0, 0, "R5");
        drive(3, 32'h0, 32'h8765_4321, 0, 31, 1, 0, 0, "R5");
        // R6 msb below lsb
        drive(0, 32'hFFFF_FFFF, 32'h0, 4, 3, 1, 0, 0, "R6");
        drive(1, 32'hFFFF_FFFF, 32'h1, 20, 0, 1, 0, 0, "R6");
        // R7 extract span
        drive(2, 32'h0, 32'hFFFF_FFFF, 16, 16, 1, 0, 0, "R7");
        drive(3, 32'h0, 32'hFFFF_FFFF, 1, 31, 1, 0, 0, "R7");
        drive(3, 32'h0, 32'h8000_0000, 16, 15, 1, 0, 0, "R7");
        // R8 program-counter register operands
        drive(0, 32'hFFFF_FFFF, 32'h0, 0, 7, 1, 1, 0, "R8");
        drive(2, 32'h0, 32'hFFFF_FFFF, 0, 7, 1, 1, 0, "R8");
        drive(1, 32'h0, 32'hFFFF_FFFF, 0, 7, 1, 0, 1, "R8");
        drive(0, 32'hFFFF_FFFF, 32'h0, 0, 7, 1, 0, 1, "R8");
        drive(2, 32'h0, 32'hFFFF_FFFF, 0, 7, 1, 0, 1, "R8");
        drive(3, 32'h0, 32'hFFFF_FFFF, 0, 7, 1, 0, 1, "R8");
        // R9 condition failed
        drive(1, 32'h1111_1111, 32'hFFFF_FFFF, 4, 11, 0, 0, 0, "R9");
        drive(3, 32'h0, 32'hFFFF_FFFF, 0, 7, 0, 0, 0, "R9");
        // R10 unpredictable outranks the condition
        drive(0, 32'hFFFF_FFFF, 32'h0, 9, 2, 0, 0, 0, "R10");
        drive(2, 32'h0, 32'hFFFF_FFFF, 0, 3, 0, 1, 0, "R10");
        idle(3);

        check("R11 pulse count", 32'(pulses), 32'(issued));
        check("R11 queue drained", 32'(sb_q.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule